// File: doc/BRIEF.md
# Cubic Spline DC-Bias Generator

This block produces one 16-bit signed sample per clock that follows a cubic polynomial in time. The polynomial is evaluated without multipliers. Three cascaded forward-difference accumulators each add their neighbour once per sample. A host loads the four coefficients as 16-bit words through an addressed write port. The words land in a shadow bank and do not disturb the running waveform. A trigger strobe carries one mask bit per channel. When this channel's bit is set, the shadow bank is copied into the accumulators and the new segment starts.

The coefficients use fixed-point scales in which the full 16-bit code range stands for the full output swing. The constant term is a plain 16-bit code. The slope is 32 bits, with the sample code in its upper half. The second- and third-order terms are 48 bits, scaled by 2^48 per full swing, and already carry their Taylor factors of 2 and 6. The hardware therefore only adds. Several instances share the write and trigger buses and are told apart by a channel parameter. Serialisation toward the converter, gain and offset trimming, and unit conversion stay outside the block.

Top module: `cubic_bias_gen`

## Requirements
- R1: After reset both the shadow bank and the running accumulators are zero, so the sample is 0 and stays 0. A trigger issued before any write also gives 0.
- R2: A write to this channel changes only the shadow bank. The output keeps following the running segment until the next own trigger, and the written words are still held after that trigger.
- R3: In the cycle after an own trigger (trig_valid_i high with trig_mask_i[CH_ID] set), sample_o equals the shadow constant word a0.
- R4: With only a0 and slope a1 loaded, the sample n cycles after loading is bits [31:16] of ({a0,16'h0} + n*a1) mod 2^32, so the fraction in a1[15:0] carries into the code.
- R5: The 48-bit term a2 adds to a 48-bit velocity every sample. The upper 32 bits of that velocity (bits [47:16]) add to the 32-bit position, so a2 = 2^32 makes the sample follow n(n-1)/2.
- R6: The 48-bit term a3 adds to the a2 accumulator every sample, so a3 = 2^32 alone makes the sample follow n(n-1)(n-2)/6. All three updates use the values from before the edge.
- R7: A write whose channel field (wr_addr_i[15:8]) differs from CH_ID does not change this channel's shadow bank.
- R8: A trigger whose mask bit for CH_ID is clear has no effect. The running segment continues unchanged.
- R9: The sample is the top 16 bits of the position and wraps modulo 2^16 in both directions, with no saturation.
- R10: Word indices (wr_addr_i[7:0]) are 0:a0, 1:a1[15:0], 2:a1[31:16], 3:a2[15:0], 4:a2[31:16], 5:a2[47:32], 6:a3[15:0], 7:a3[31:16], 8:a3[47:32]. Indices 9 and above are ignored.
- R11: A repeated own trigger with no writes between restarts the same segment from a0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Coefficient word write strobe |
| wr_addr_i | input | 16 | Channel field [15:8] and word index [7:0] |
| wr_data_i | input | 16 | Coefficient word |
| trig_valid_i | input | 1 | Trigger strobe |
| trig_mask_i | input | NUM_CH | One load-enable bit per channel |
| sample_o | output | 16 | Two's-complement output sample |

## Verification
The hardest case to reach is a segment that keeps running while its shadow bank is rewritten and a trigger for other channels passes by. The check must show that neither event bends the trajectory, and that the rewritten words still take effect later. The stimulus starts a long ramp and queues 30 expected samples. While those samples are being compared, it writes a complete new coefficient set to this channel and fires a trigger whose mask has every bit except this channel's. A later own trigger then has to start the newly written segment. The reference trajectory is built by summing the closed-form velocity at every step, so the truncation of the velocity's lower 16 bits is covered when a2 carries fractional bits.

// File: rtl/cubic_bias_pkg.sv
package cubic_bias_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned SLOPE_W  = 32;
  localparam int unsigned HIGH_W   = 48;
  localparam int unsigned NUM_WORDS = 1 + SLOPE_W / WORD_W + 2 * (HIGH_W / WORD_W);

  typedef struct packed {
    logic [HIGH_W-1:0]  a3;
    logic [HIGH_W-1:0]  a2;
    logic [SLOPE_W-1:0] a1;
    logic [WORD_W-1:0]  a0;
  } coef_t;
endpackage

// File: rtl/cubic_shadow_bank.sv
module cubic_shadow_bank
  import cubic_bias_pkg::*;
#(
  parameter int unsigned CH_W  = 8,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CH_ID = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_valid_i,
  input  logic [CH_W+IDX_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0]     wr_data_i,
  output coef_t                 coef_o
);
  logic [CH_W-1:0]  wr_ch;
  logic [IDX_W-1:0] wr_idx;
  logic             ch_hit;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words;

  assign wr_ch  = wr_addr_i[CH_W+IDX_W-1:IDX_W];
  assign wr_idx = wr_addr_i[IDX_W-1:0];
  assign ch_hit = wr_valid_i && (wr_ch == CH_W'(CH_ID));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               word_q <= '0;
      else if (ch_hit && wr_idx == IDX_W'(w))    word_q <= wr_data_i;
    end
    assign words[w] = word_q;
  end

  // word order 0..8: a0, a1 lo..hi, a2 lo..hi, a3 lo..hi
  assign coef_o.a0 = words[0];
  assign coef_o.a1 = {words[2], words[1]};
  assign coef_o.a2 = {words[5], words[4], words[3]};
  assign coef_o.a3 = {words[8], words[7], words[6]};

  assert_foreign_ch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ch != CH_W'(CH_ID)) |=> $stable(words));

  assert_bad_index_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_idx >= IDX_W'(NUM_WORDS)) |=> $stable(words));
endmodule

// File: rtl/cubic_accum.sv
module cubic_accum
  import cubic_bias_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  coef_t             coef_i,
  output logic [WORD_W-1:0] sample_o
);
  localparam int unsigned POS_W  = SLOPE_W;
  localparam int unsigned FRAC_W = POS_W - WORD_W;
  localparam int unsigned VPAD_W = HIGH_W - SLOPE_W;

  logic [POS_W-1:0]  pos_q;
  logic [HIGH_W-1:0] vel_q, acc_q, jerk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      vel_q  <= '0;
      acc_q  <= '0;
      jerk_q <= '0;
    end else if (load_i) begin
      pos_q  <= {coef_i.a0, {FRAC_W{1'b0}}};
      vel_q  <= {coef_i.a1, {VPAD_W{1'b0}}};
      acc_q  <= coef_i.a2;
      jerk_q <= coef_i.a3;
    end else begin
      // all three stages use pre-edge values
      pos_q <= pos_q + vel_q[HIGH_W-1 -: POS_W];
      vel_q <= vel_q + acc_q;
      acc_q <= acc_q + jerk_q;
    end
  end

  assign sample_o = pos_q[POS_W-1 -: WORD_W];

  assert_jerk_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(jerk_q));

  assert_pos_steps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && vel_q == '0) |=> pos_q == $past(pos_q));
endmodule

// File: rtl/cubic_bias_gen.sv
module cubic_bias_gen
  import cubic_bias_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned CH_ID  = 0,
  parameter int unsigned CH_W   = 8,
  parameter int unsigned IDX_W  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_valid_i,
  input  logic [CH_W+IDX_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0]     wr_data_i,
  input  logic                  trig_valid_i,
  input  logic [NUM_CH-1:0]     trig_mask_i,
  output logic [WORD_W-1:0]     sample_o
);
  coef_t shadow;
  logic  load;

  assign load = trig_valid_i && trig_mask_i[CH_ID];

  cubic_shadow_bank #(.CH_W(CH_W), .IDX_W(IDX_W), .CH_ID(CH_ID)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_valid_i(wr_valid_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .coef_o    (shadow)
  );

  cubic_accum u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .coef_i  (shadow),
    .sample_o(sample_o)
  );

  assert_load_a0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> sample_o == $past(shadow.a0));

  assert_load_keeps_shadow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !wr_valid_i) |=> $stable(shadow));
endmodule

// File: tb/cubic_bias_gen_test.sv
module cubic_bias_gen_test;
  localparam int PERIOD = 8;
  localparam int NCH    = 16;
  localparam int OWN    = 3;
  localparam logic [NCH-1:0] OWN_MASK = NCH'(1) << OWN;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trig_valid = 1'b0;
  logic [NCH-1:0] trig_mask = '0;
  logic [15:0] sample;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  cubic_bias_gen #(.NUM_CH(NCH), .CH_ID(OWN)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .trig_valid_i(trig_valid), .trig_mask_i(trig_mask),
    .sample_o(sample)
  );

  // reference: position plus the sum of truncated closed-form velocities
  function automatic logic [15:0] ref_sample(logic [15:0] a0, logic [31:0] a1,
                                             logic [47:0] a2, logic [47:0] a3, int n);
    logic [63:0] pos, vel, k;
    pos = {32'h0, a0, 16'h0};
    for (int i = 0; i < n; i++) begin
      k   = 64'(i);
      vel = ({16'h0, a1, 16'h0} + k * {16'h0, a2} + ((k * (k - 1)) / 2) * {16'h0, a3})
            & 64'hFFFF_FFFF_FFFF;
      pos = (pos + (vel >> 16)) & 64'hFFFF_FFFF;
    end
    return pos[31:16];
  endfunction

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (exp_q.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (sample !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, sample, e);
        end
      end
    end
  end

  task automatic push_const(logic [15:0] v, int n, string t);
    for (int i = 0; i < n; i++) begin exp_q.push_back(v); tag_q.push_back(t); end
  endtask

  task automatic write_word(int ch, int idx, logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = {8'(ch), 8'(idx)};
    wr_data  = d;
  endtask

  task automatic load_set(int ch, logic [15:0] a0, logic [31:0] a1,
                          logic [47:0] a2, logic [47:0] a3);
    write_word(ch, 0, a0);
    write_word(ch, 1, a1[15:0]);
    write_word(ch, 2, a1[31:16]);
    write_word(ch, 3, a2[15:0]);
    write_word(ch, 4, a2[31:16]);
    write_word(ch, 5, a2[47:32]);
    write_word(ch, 6, a3[15:0]);
    write_word(ch, 7, a3[31:16]);
    write_word(ch, 8, a3[47:32]);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic fire(logic [NCH-1:0] m);
    @(negedge clk);
    trig_valid = 1'b1;
    trig_mask  = m;
    @(negedge clk);
    trig_valid = 1'b0;
    trig_mask  = '0;
  endtask

  task automatic trig_expect(logic [15:0] a0, logic [31:0] a1, logic [47:0] a2,
                             logic [47:0] a3, int n, string t, bit wait_done);
    @(negedge clk);
    trig_valid = 1'b1;
    trig_mask  = OWN_MASK;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(ref_sample(a0, a1, a2, a3, i));
      tag_q.push_back(t);
    end
    @(negedge clk);
    trig_valid = 1'b0;
    trig_mask  = '0;
    if (wait_done) wait (exp_q.size() == 0);
  endtask

  task automatic run_case(logic [15:0] a0, logic [31:0] a1, logic [47:0] a2,
                          logic [47:0] a3, int n, string t);
    load_set(OWN, a0, a1, a2, a3);
    trig_expect(a0, a1, a2, a3, n, t, 1'b1);
  endtask

  // driver
  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    push_const(16'h0000, 5, "R1 reset");
    wait (exp_q.size() == 0);
    trig_expect(16'h0, 32'h0, 48'h0, 48'h0, 5, "R1 trigger with cleared shadow", 1'b1);

    // shadow write alone leaves the output at zero
    load_set(OWN, 16'h1234, 32'h0, 48'h0, 48'h0);
    push_const(16'h0000, 3, "R2 write without trigger");
    wait (exp_q.size() == 0);
    trig_expect(16'h1234, 32'h0, 48'h0, 48'h0, 5, "R3 load a0", 1'b1);

    run_case(16'h0100, 32'h0000_8000, 48'h0, 48'h0, 8, "R4 half-code ramp");
    run_case(16'hFFF0, 32'h0003_4000, 48'h0, 48'h0, 8, "R4 fractional ramp");
    run_case(16'h7FF0, 32'h0004_0000, 48'h0, 48'h0, 8, "R9 wrap upward");
    run_case(16'h0002, 32'hFFFF_0000, 48'h0, 48'h0, 6, "R9 wrap downward");
    run_case(16'h0000, 32'h0, 48'h0001_0000_0000, 48'h0, 10, "R5 quadratic");
    run_case(16'h0010, 32'h0000_1234, 48'h0000_8000_8000, 48'h0, 12, "R5 fractional a2");
    run_case(16'h0000, 32'h0, 48'h0, 48'h0001_0000_0000, 10, "R6 cubic");
    run_case(16'hFF00, 32'h0002_0001, 48'h0000_0001_0003, 48'h0002_0003_0004, 12,
             "R6 R10 all words");

    // R8: rewrite shadow and fire a foreign trigger while a segment runs
    load_set(OWN, 16'h0500, 32'h0001_0000, 48'h0, 48'h0);
    trig_expect(16'h0500, 32'h0001_0000, 48'h0, 48'h0, 30, "R8 R2 running segment", 1'b0);
    load_set(OWN, 16'h4000, 32'h0, 48'h0, 48'h0);
    fire(~OWN_MASK);
    wait (exp_q.size() == 0);

    trig_expect(16'h4000, 32'h0, 48'h0, 48'h0, 4, "R2 shadow applied", 1'b1);
    trig_expect(16'h4000, 32'h0, 48'h0, 48'h0, 4, "R11 retrigger", 1'b1);

    load_set(OWN + 1, 16'h7777, 32'h7777_7777, 48'h7777_7777_7777, 48'h7777_7777_7777);
    trig_expect(16'h4000, 32'h0, 48'h0, 48'h0, 4, "R7 foreign channel write", 1'b1);

    write_word(OWN, 9, 16'h6666);
    write_word(OWN, 10, 16'h6666);
    write_word(OWN, 255, 16'h6666);
    @(negedge clk);
    wr_valid = 1'b0;
    trig_expect(16'h4000, 32'h0, 48'h0, 48'h0, 4, "R10 invalid index", 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule